// File: doc/BRIEF.md
# Packet Buffer Allocator with Completion Queues

This block hands out packet buffers from a fixed pool of `NSLOT` slots, numbered 0 to `NSLOT-1`. One occupancy bitmap serves both directions. The host drives memory-management commands through a 4-bit opcode. These commands allocate transmit buffers, release slots, move packet numbers through a transmit completion queue and a receive completion queue, and reset the pool. The receive side asks for a buffer with a single strobe. A granted slot goes straight onto the receive completion queue.

The block also keeps the interrupt status byte. Two of its bits follow the queue states and two are sticky flags. An 8-bit mask selects which status bits drive the interrupt line. The host reads the heads of both queues from one status word. It reads the last transmit allocation from the allocation-number byte. Frame transmission and the contents of the buffer memory belong to other blocks. `tx_done` tells this block that a frame went out.

Top module: `pkt_buf_alloc`

## Requirements
- R1: After synchronous reset, the outputs are as follows: `alloc_num` = 0x80, `fifo_status` = 0x8080, `int_status` = 0x04, `int_mask` = 0x00, `irq` = 0, `rx_grant` = 0 and `q_err` = 0. All slots are free and both queues are empty.
- R2: Opcode 2 (allocate for transmit) takes the lowest-numbered free slot. One cycle later, `alloc_num` holds that number and allocation status bit 3 is set.
- R3: Opcode 2 with no free slot leaves `alloc_num`, the bitmap and status bit 3 unchanged.
- R4: Opcode 12 (enqueue) pushes `pkt_sel` onto the transmit queue only while `tx_enable` is 1. With `tx_enable` at 0 it has no effect.
- R5: `fifo_status[7:0]` is the transmit queue head and `fifo_status[15:8]` is the receive queue head. Each byte reads 0x80 when its queue is empty, and otherwise holds the packet number with bit 7 at 0.
- R6: Status bit 0 is 1 while the receive queue is not empty. Bit 2 is 1 while the transmit queue is empty. A `tx_done` pulse sets the sticky bit 1. Bits 7:4 read 0.
- R7: An interrupt-register write (`irq_wr`) loads `int_mask` from `irq_mask_in`. If `irq_ack_tx` is 1 while bit 1 is set, the write clears bit 1 and pops the transmit queue head. If `tx_done` arrives in the same cycle, bit 1 stays set.
- R8: `irq` is 1 exactly when `int_mask & int_status` is non-zero.
- R9: A pulse on `alloc_rd` clears status bit 3. A successful allocation in the same cycle wins.
- R10: Opcode 10 frees slot `pkt_sel`. Opcode 8 frees the receive queue head's slot and pops that entry. Opcode 6 pops the receive queue head and keeps its slot allocated. Opcode 7 pops the transmit queue head.
- R11: Opcode 4 frees every slot and empties both queues. Opcodes 0 and 14 change nothing visible.
- R12: When no command is present, `rx_alloc_req` takes the lowest free slot and pushes it onto the receive queue, and `rx_grant` pulses for one cycle. With no free slot there is no grant and no change.
- R13: A push to a full queue or a pop from an empty queue is dropped and sets the sticky `q_err` flag. Only reset clears `q_err`.
- R14: While `cmd_valid` is 1, `rx_alloc_req` and `irq_wr` in the same cycle are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Host command strobe |
| cmd_op | input | 4 | Opcode, bits 7:4 of the host command word |
| pkt_sel | input | PN_W | Packet number from the packet-number register |
| tx_enable | input | 1 | Transmit enable control bit |
| rx_alloc_req | input | 1 | Receive-side buffer request |
| tx_done | input | 1 | Frame transmitted strobe |
| irq_wr | input | 1 | Interrupt register write strobe |
| irq_mask_in | input | 8 | Mask byte of the interrupt write |
| irq_ack_tx | input | 1 | Bit 1 of the interrupt write (transmit acknowledge) |
| alloc_rd | input | 1 | Host read of the allocation-number byte |
| alloc_num | output | 8 | Last transmit allocation number |
| fifo_status | output | 16 | Queue heads with empty flags |
| int_status | output | 8 | Interrupt status byte |
| int_mask | output | 8 | Interrupt mask byte |
| irq | output | 1 | Interrupt line |
| rx_grant | output | 1 | Receive allocation accepted, one-cycle pulse |
| q_err | output | 1 | Sticky queue overflow or underflow |

## Verification
The bench fills the pool completely and then asks for one more slot from both the transmit and the receive side. A scan that does not stop at the lowest free slot, or that wraps around, would return a wrong or duplicate number there. It pops a receive head with and without release, then allocates again to see whether the slot came back. A design that confuses opcodes 6 and 8 hands out a different number. It pushes seventeen entries into a sixteen-deep queue, pops an empty one, and collides commands with receive requests and interrupt writes. A dropped guard there corrupts a pointer, misses the error flag, or grants a slot the host never sees.

// File: rtl/pba_pkg.sv
package pba_pkg;

    typedef enum logic [3:0] {
        OP_NOP      = 4'd0,
        OP_ALLOC_TX = 4'd2,
        OP_MMU_RST  = 4'd4,
        OP_RX_DROP  = 4'd6,
        OP_TX_DROP  = 4'd7,
        OP_RX_FREE  = 4'd8,
        OP_FREE_SEL = 4'd10,
        OP_TX_PUSH  = 4'd12,
        OP_FIFO_RST = 4'd14
    } mmu_op_e;

    localparam int IRQ_RX    = 0;
    localparam int IRQ_TX    = 1;
    localparam int IRQ_TXE   = 2;
    localparam int IRQ_ALLOC = 3;

    localparam logic [7:0] EMPTY_BYTE = 8'h80;

    typedef struct packed {
        logic push;
        logic pop;
        logic clr;
    } q_ctl_t;

    function automatic logic [7:0] head_byte(input logic empty, input logic [6:0] num);
        return empty ? EMPTY_BYTE : {1'b0, num};
    endfunction

endpackage

// File: rtl/pba_bitmap.sv
module pba_bitmap #(
    parameter int NSLOT = 16,
    localparam int PN_W = $clog2(NSLOT)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clr_all,
    input  logic            take,
    input  logic            give,
    input  logic [PN_W-1:0] give_num,
    output logic            free_any,
    output logic [PN_W-1:0] free_num
);
    logic [NSLOT-1:0] used;

    always_comb begin
        free_any = 1'b0;
        free_num = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (!used[i]) begin
                free_any = 1'b1;
                free_num = PN_W'(i);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || clr_all) begin
            used <= '0;
        end else begin
            if (take && free_any) used[free_num] <= 1'b1;
            if (give)             used[give_num] <= 1'b0;
        end
    end
endmodule

// File: rtl/pba_queue.sv
module pba_queue #(
    parameter int DEPTH = 16,
    parameter int W     = 4,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  pba_pkg::q_ctl_t  ctl,
    input  logic [W-1:0]     wdata,
    output logic [W-1:0]     head,
    output logic             empty,
    output logic             full,
    output logic             err
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] count;
    logic             push_ok, pop_ok;

    assign empty   = (count == '0);
    assign full    = (count == CNT_W'(DEPTH));
    assign head    = mem[rd_ptr];
    assign push_ok = ctl.push && !full;
    assign pop_ok  = ctl.pop && !empty;
    assign err     = !ctl.clr && ((ctl.push && full) || (ctl.pop && empty));

    always_ff @(posedge clk) begin
        if (push_ok) mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst || ctl.clr) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= wr_ptr + 1'b1;
            if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
            if (push_ok && !pop_ok)      count <= count + 1'b1;
            else if (pop_ok && !push_ok) count <= count - 1'b1;
        end
    end
endmodule

// File: rtl/pba_irq.sv
module pba_irq
    import pba_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tx_done,
    input  logic       wr,
    input  logic [7:0] mask_in,
    input  logic       ack_tx,
    input  logic       alloc_set,
    input  logic       alloc_clr,
    input  logic       rx_nonempty,
    input  logic       tx_empty,
    output logic       tx_pop,
    output logic [7:0] status,
    output logic [7:0] mask,
    output logic       irq
);
    logic tx_flag, alloc_flag;

    assign tx_pop = wr && ack_tx && tx_flag;

    always_comb begin
        status            = '0;
        status[IRQ_RX]    = rx_nonempty;
        status[IRQ_TX]    = tx_flag;
        status[IRQ_TXE]   = tx_empty;
        status[IRQ_ALLOC] = alloc_flag;
    end

    assign irq = |(status & mask);

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_flag    <= 1'b0;
            alloc_flag <= 1'b0;
            mask       <= '0;
        end else begin
            if (wr) mask <= mask_in;
            if (tx_done)     tx_flag <= 1'b1;
            else if (tx_pop) tx_flag <= 1'b0;
            if (alloc_set)      alloc_flag <= 1'b1;
            else if (alloc_clr) alloc_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/pkt_buf_alloc.sv
module pkt_buf_alloc
    import pba_pkg::*;
#(
    parameter int NSLOT = 16,
    localparam int PN_W = $clog2(NSLOT)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cmd_valid,
    input  logic [3:0]      cmd_op,
    input  logic [PN_W-1:0] pkt_sel,
    input  logic            tx_enable,
    input  logic            rx_alloc_req,
    input  logic            tx_done,
    input  logic            irq_wr,
    input  logic [7:0]      irq_mask_in,
    input  logic            irq_ack_tx,
    input  logic            alloc_rd,
    output logic [7:0]      alloc_num,
    output logic [15:0]     fifo_status,
    output logic [7:0]      int_status,
    output logic [7:0]      int_mask,
    output logic            irq,
    output logic            rx_grant,
    output logic            q_err
);
    mmu_op_e         op;
    logic            is_op_alloc, is_op_rst, is_op_rxdrop, is_op_txdrop;
    logic            is_op_rxfree, is_op_freesel, is_op_push;
    logic            free_any, rx_try, rx_ok, rx_full_err, alloc_ok;
    logic            give;
    logic [PN_W-1:0] free_num, give_num;
    logic [PN_W-1:0] txq_head, rxq_head;
    logic            txq_empty, txq_full, txq_err;
    logic            rxq_empty, rxq_full, rxq_err;
    logic            tx_pop_ack, host_wr;
    q_ctl_t          txq_ctl, rxq_ctl;

    assign op             = mmu_op_e'(cmd_op);
    assign is_op_alloc    = cmd_valid && (op == OP_ALLOC_TX);
    assign is_op_rst      = cmd_valid && (op == OP_MMU_RST);
    assign is_op_rxdrop   = cmd_valid && (op == OP_RX_DROP);
    assign is_op_txdrop   = cmd_valid && (op == OP_TX_DROP);
    assign is_op_rxfree   = cmd_valid && (op == OP_RX_FREE);
    assign is_op_freesel  = cmd_valid && (op == OP_FREE_SEL);
    assign is_op_push     = cmd_valid && (op == OP_TX_PUSH);

    // Commands own the cycle; receive requests and interrupt writes wait.
    assign rx_try      = rx_alloc_req && !cmd_valid;
    assign rx_ok       = rx_try && free_any && !rxq_full;
    assign rx_full_err = rx_try && free_any && rxq_full;
    assign alloc_ok    = is_op_alloc && free_any;
    assign host_wr     = irq_wr && !cmd_valid;

    assign give     = is_op_freesel || (is_op_rxfree && !rxq_empty);
    assign give_num = is_op_rxfree ? rxq_head : pkt_sel;

    pba_bitmap #(.NSLOT(NSLOT)) u_bitmap (
        .clk      (clk),
        .rst      (rst),
        .clr_all  (is_op_rst),
        .take     (is_op_alloc || rx_ok),
        .give     (give),
        .give_num (give_num),
        .free_any (free_any),
        .free_num (free_num)
    );

    always_comb begin
        txq_ctl.push = is_op_push && tx_enable;
        txq_ctl.pop  = is_op_txdrop || tx_pop_ack;
        txq_ctl.clr  = is_op_rst;
        rxq_ctl.push = rx_ok;
        rxq_ctl.pop  = is_op_rxdrop || is_op_rxfree;
        rxq_ctl.clr  = is_op_rst;
    end

    pba_queue #(.DEPTH(NSLOT), .W(PN_W)) u_txq (
        .clk   (clk),
        .rst   (rst),
        .ctl   (txq_ctl),
        .wdata (pkt_sel),
        .head  (txq_head),
        .empty (txq_empty),
        .full  (txq_full),
        .err   (txq_err)
    );

    pba_queue #(.DEPTH(NSLOT), .W(PN_W)) u_rxq (
        .clk   (clk),
        .rst   (rst),
        .ctl   (rxq_ctl),
        .wdata (free_num),
        .head  (rxq_head),
        .empty (rxq_empty),
        .full  (rxq_full),
        .err   (rxq_err)
    );

    pba_irq u_irq (
        .clk         (clk),
        .rst         (rst),
        .tx_done     (tx_done),
        .wr          (host_wr),
        .mask_in     (irq_mask_in),
        .ack_tx      (irq_ack_tx),
        .alloc_set   (alloc_ok),
        .alloc_clr   (alloc_rd),
        .rx_nonempty (!rxq_empty),
        .tx_empty    (txq_empty),
        .tx_pop      (tx_pop_ack),
        .status      (int_status),
        .mask        (int_mask),
        .irq         (irq)
    );

    assign fifo_status = {head_byte(rxq_empty, 7'(rxq_head)),
                          head_byte(txq_empty, 7'(txq_head))};

    always_ff @(posedge clk) begin
        if (rst) begin
            alloc_num <= EMPTY_BYTE;
            rx_grant  <= 1'b0;
            q_err     <= 1'b0;
        end else begin
            if (alloc_ok) alloc_num <= 8'(free_num);
            rx_grant <= rx_ok;
            q_err    <= q_err || txq_err || rxq_err || rx_full_err;
        end
    end
endmodule

// File: rtl/pba_checker.sv
module pba_checker (
    input logic        clk,
    input logic        rst,
    input logic        cmd_valid,
    input logic [7:0]  alloc_num,
    input logic [15:0] fifo_status,
    input logic [7:0]  int_status,
    input logic [7:0]  int_mask,
    input logic        irq,
    input logic        rx_grant,
    input logic        q_err
);
    p_reset_state_r1: assert property (@(posedge clk)
        $past(rst) |-> (fifo_status == 16'h8080 && alloc_num == 8'h80 && !q_err));

    p_alloc_flag_r2: assert property (@(posedge clk) disable iff (rst)
        !$stable(alloc_num) |-> int_status[3]);

    p_no_cmd_keeps_num_r3: assert property (@(posedge clk) disable iff (rst)
        !cmd_valid |=> $stable(alloc_num));

    p_tx_empty_bit_r6: assert property (@(posedge clk) disable iff (rst)
        int_status[2] == fifo_status[7]);

    p_rx_bit_r6: assert property (@(posedge clk) disable iff (rst)
        int_status[0] == !fifo_status[15]);

    p_masked_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (int_mask == 8'h00) |-> !irq);

    p_grant_visible_r12: assert property (@(posedge clk) disable iff (rst)
        rx_grant |-> !fifo_status[15]);

    p_err_sticky_r13: assert property (@(posedge clk) disable iff (rst)
        q_err |=> q_err);

    p_grant_blocked_r14: assert property (@(posedge clk) disable iff (rst)
        cmd_valid |=> !rx_grant);
endmodule

bind pkt_buf_alloc pba_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .cmd_valid   (cmd_valid),
    .alloc_num   (alloc_num),
    .fifo_status (fifo_status),
    .int_status  (int_status),
    .int_mask    (int_mask),
    .irq         (irq),
    .rx_grant    (rx_grant),
    .q_err       (q_err)
);

// File: tb/pkt_buf_alloc_test.sv
`timescale 1ns/1ps
module pkt_buf_alloc_test;
    localparam int NSLOT = 16;
    localparam int PN_W  = 4;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            cmd_valid = 1'b0;
    logic [3:0]      cmd_op = '0;
    logic [PN_W-1:0] pkt_sel = '0;
    logic            tx_enable = 1'b1;
    logic            rx_alloc_req = 1'b0;
    logic            tx_done = 1'b0;
    logic            irq_wr = 1'b0;
    logic [7:0]      irq_mask_in = '0;
    logic            irq_ack_tx = 1'b0;
    logic            alloc_rd = 1'b0;
    logic [7:0]      alloc_num;
    logic [15:0]     fifo_status;
    logic [7:0]      int_status;
    logic [7:0]      int_mask;
    logic            irq;
    logic            rx_grant;
    logic            q_err;

    always #2.5 clk = ~clk;

    pkt_buf_alloc #(.NSLOT(NSLOT)) uut (.*);

    // Reference state
    logic [NSLOT-1:0] m_used;
    int               m_txq[$];
    int               m_rxq[$];
    logic [7:0]       m_alloc_num, m_mask;
    logic             m_txint, m_allocint, m_err, m_grant;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    function automatic int lowest_free();
        for (int i = 0; i < NSLOT; i++) if (!m_used[i]) return i;
        return -1;
    endfunction

    function automatic logic [7:0] exp_head(ref int q[$]);
        return (q.size() == 0) ? 8'h80 : 8'(q[0]);
    endfunction

    function automatic logic [7:0] exp_status();
        logic [7:0] s = '0;
        s[0] = (m_rxq.size() != 0);
        s[1] = m_txint;
        s[2] = (m_txq.size() == 0);
        s[3] = m_allocint;
        return s;
    endfunction

    task automatic model_reset();
        m_used = '0; m_txq.delete(); m_rxq.delete();
        m_alloc_num = 8'h80; m_mask = '0;
        m_txint = 0; m_allocint = 0; m_err = 0; m_grant = 0;
    endtask

    task automatic model_step();
        int f;
        m_grant = 0;
        if (alloc_rd) m_allocint = 0;
        if (cmd_valid) begin
            case (cmd_op)
                4'd2: begin
                    f = lowest_free();
                    if (f >= 0) begin m_used[f] = 1; m_alloc_num = 8'(f); m_allocint = 1; end
                end
                4'd4: begin m_used = '0; m_txq.delete(); m_rxq.delete(); end
                4'd6: if (m_rxq.size() == 0) m_err = 1; else void'(m_rxq.pop_front());
                4'd7: if (m_txq.size() == 0) m_err = 1; else void'(m_txq.pop_front());
                4'd8: if (m_rxq.size() == 0) m_err = 1;
                      else begin m_used[m_rxq[0]] = 0; void'(m_rxq.pop_front()); end
                4'd10: m_used[pkt_sel] = 0;
                4'd12: if (tx_enable) begin
                           if (m_txq.size() == NSLOT) m_err = 1; else m_txq.push_back(int'(pkt_sel));
                       end
                default: ;
            endcase
        end else begin
            if (rx_alloc_req) begin
                f = lowest_free();
                if (f >= 0) begin
                    if (m_rxq.size() == NSLOT) m_err = 1;
                    else begin m_used[f] = 1; m_rxq.push_back(f); m_grant = 1; end
                end
            end
            if (irq_wr) begin
                m_mask = irq_mask_in;
                if (irq_ack_tx && m_txint) begin
                    if (m_txq.size() == 0) m_err = 1; else void'(m_txq.pop_front());
                    m_txint = 0;
                end
            end
        end
        if (tx_done) m_txint = 1;
    endtask

    task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic check_all(string req);
        logic [7:0] st = exp_status();
        chk(req, "alloc_num",   16'(alloc_num),  16'(m_alloc_num));
        chk(req, "fifo_status", fifo_status,     {exp_head(m_rxq), exp_head(m_txq)});
        chk(req, "int_status",  16'(int_status), 16'(st));
        chk(req, "int_mask",    16'(int_mask),   16'(m_mask));
        chk(req, "irq R8",      16'(irq),        16'(|(st & m_mask)));
        chk(req, "rx_grant",    16'(rx_grant),   16'(m_grant));
        chk(req, "q_err",       16'(q_err),      16'(m_err));
    endtask

    task automatic idle_inputs();
        cmd_valid = 0; rx_alloc_req = 0; tx_done = 0; irq_wr = 0;
        irq_ack_tx = 0; alloc_rd = 0;
    endtask

    // Inputs are driven at a falling edge; this runs one rising edge and checks.
    task automatic run_cycle(string req);
        @(posedge clk);
        model_step();
        @(negedge clk);
        idle_inputs();
        check_all(req);
    endtask

    task automatic do_cmd(logic [3:0] op, int sel, string req);
        cmd_valid = 1; cmd_op = op; pkt_sel = PN_W'(sel);
        run_cycle(req);
    endtask

    task automatic do_rx(string req);
        rx_alloc_req = 1;
        run_cycle(req);
    endtask

    task automatic do_irq_wr(logic [7:0] mask, logic ack, string req);
        irq_wr = 1; irq_mask_in = mask; irq_ack_tx = ack;
        run_cycle(req);
    endtask

    task automatic reset_dut();
        rst = 1; idle_inputs();
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 0;
        model_reset();
        check_all("R1");
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        reset_dut();

        // R2: lowest slot first, R9: read clears flag
        do_cmd(4'd2, 0, "R2");
        do_cmd(4'd2, 0, "R2");
        do_cmd(4'd2, 0, "R2");
        alloc_rd = 1; run_cycle("R9");
        // R4/R5: enqueue with and without tx_enable
        tx_enable = 1; do_cmd(4'd12, 1, "R4");
        tx_enable = 0; do_cmd(4'd12, 2, "R4");
        tx_enable = 1; do_cmd(4'd12, 2, "R5");
        // R6/R8/R7: tx_done, mask, acknowledge pops head
        do_irq_wr(8'h02, 0, "R8");
        tx_done = 1; run_cycle("R6");
        do_irq_wr(8'h02, 1, "R7");
        tx_done = 1; run_cycle("R6");
        irq_wr = 1; irq_mask_in = 8'h03; irq_ack_tx = 1; tx_done = 1; run_cycle("R7");
        // R12, R10: receive allocation, pop with and without release
        do_rx("R12");
        do_rx("R12");
        do_cmd(4'd6, 0, "R10");
        do_cmd(4'd2, 0, "R10");
        do_cmd(4'd8, 0, "R10");
        do_cmd(4'd2, 0, "R10");
        do_cmd(4'd10, 3, "R10");
        do_cmd(4'd2, 0, "R10");
        do_cmd(4'd7, 0, "R10");
        // R11: no-op and FIFO reset leave state
        do_cmd(4'd0, 0, "R11");
        do_cmd(4'd14, 0, "R11");
        // R3, R12: exhaust the pool
        for (int i = 0; i < NSLOT; i++) do_cmd(4'd2, 0, "R3");
        do_cmd(4'd2, 0, "R3");
        do_rx("R12");
        // R14: command and receive request / interrupt write together
        do_cmd(4'd10, 5, "R10");
        cmd_valid = 1; cmd_op = 4'd0; rx_alloc_req = 1; irq_wr = 1; irq_mask_in = 8'hff;
        run_cycle("R14");
        do_rx("R12");
        // R11: MMU reset
        do_cmd(4'd4, 0, "R11");
        do_cmd(4'd2, 0, "R11");
        // R13: overflow after a fresh reset
        reset_dut();
        for (int i = 0; i <= NSLOT; i++) do_cmd(4'd12, i % NSLOT, "R13");
        reset_dut();
        do_cmd(4'd7, 0, "R13");
        do_cmd(4'd0, 0, "R13");
        reset_dut();
        do_cmd(4'd8, 0, "R13");

        // Random mix
        reset_dut();
        for (int n = 0; n < 1500; n++) begin
            int r = int'($urandom % 16);
            tx_enable = ($urandom % 8) != 0;
            pkt_sel   = PN_W'($urandom);
            if (r < 4) begin
                cmd_valid = 1; cmd_op = 4'd2;
            end else if (r < 6) begin
                cmd_valid = 1; cmd_op = 4'd12;
            end else if (r < 9) begin
                cmd_valid = 1;
                case ($urandom % 6)
                    0: cmd_op = 4'd6;
                    1: cmd_op = 4'd7;
                    2: cmd_op = 4'd8;
                    3: cmd_op = 4'd10;
                    4: cmd_op = 4'd14;
                    default: cmd_op = (($urandom % 8) == 0) ? 4'd4 : 4'd0;
                endcase
            end else if (r < 12) begin
                rx_alloc_req = 1;
            end else if (r < 14) begin
                irq_wr = 1; irq_mask_in = 8'($urandom); irq_ack_tx = $urandom % 2;
            end
            if (($urandom % 5) == 0) tx_done = 1;
            if (($urandom % 6) == 0) alloc_rd = 1;
            if (cmd_valid && ($urandom % 6) == 0) rx_alloc_req = 1;
            run_cycle("R12 random");
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule